// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects 32 level-sensitive interrupt lines and spreads them over a grid of 16 outputs, one per pairing of four processor cores with four interrupt pins per core. Each line carries a one-byte route. Its low nibble names the cores the line may reach, and its high nibble names the pins it may raise.

A grid output turns on when its core has at least one routed pending line and its pin has at least one routed pending line. The two conditions may be met by different lines.

A line is pending while its input is high and its enable bit is set; nothing is latched. Software reaches the routes, the enable mask and the status words through a plain synchronous register port. The port has valid, write, address, size and data signals. The enable mask is changed only through separate set and clear offsets.

Top module: `irq_router`

## Requirements
- R1: Pending status equals `irq_in & enable` with no latching. A line that drops, or whose enable bit is clear, is not pending after the next clock edge.
- R2: Byte accesses (`bus_size`=0) to offsets 0x00..0x1F write and read the route of line `offset`. Bits 3:0 select cores 0..3 and bits 7:4 select pins 0..3. Read data sits in `bus_rdata[7:0]` with upper bits zero.
- R3: A word read of 0x24 returns the enable mask. A word write to 0x28 ORs the data into the mask. A word write to 0x2C clears each mask bit where the data holds a 1.
- R4: A word read of 0x20 returns the pending status.
- R5: A word read of 0x40 + 8·n (n = 0..3) returns the pending lines whose route selects core n.
- R6: `irq_out[core*4+pin]` is 1 exactly when core `core` has a routed pending line and pin `pin` has a routed pending line. The two may come from different lines.
- R7: The following accesses are non-conforming: a byte access at 0x20 or above, a word access with address bits 1:0 nonzero, and a word access to any offset not named in R3..R5. Non-conforming writes change nothing and non-conforming reads return zero.
- R8: Word writes to 0x20, 0x24 and the per-core status offsets leave the enable mask, the status and the outputs unchanged.
- R9: After reset the enable mask and all routes are zero, and `irq_out` and `bus_rdata` are zero.
- R10: Status and `irq_out` are registered. They change at the first clock edge that samples the new input level or performs the register write. Read data appears after the edge of the read cycle, and `bus_rdata` is zero in any cycle not following a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level interrupt lines |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = byte, 1 = 32-bit word |
| bus_addr | input | 7 | Byte offset |
| bus_wdata | input | 32 | Write data (route in bits 7:0) |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 16 | Grid outputs, index core*4+pin |

## Verification
Several relations are checked by assertions on every cycle:
- pending lines never lie outside the enable mask;
- per-core status never lies outside the pending set;
- a lit grid output always has a core with pending work;
- with no write, pending follows the previous inputs and mask;
- read data is idle-zero;
- byte accesses above the route area never change the mask.

Other behaviours appear only in the bench's scenarios. These include the cross-line pairing of a core from one line with a pin from another, and the exact content of each readable offset. They also include the rejection of misaligned and unmapped word accesses, and the same-edge timing of outputs after an input change.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_LINES = 32,
  parameter int N_CORES = 4,
  parameter int N_PINS  = 4,
  parameter int AW      = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_LINES-1:0]         irq_in,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic                       bus_size,
  input  logic [AW-1:0]              bus_addr,
  input  logic [N_LINES-1:0]         bus_wdata,
  output logic [N_LINES-1:0]         bus_rdata,
  output logic [N_CORES*N_PINS-1:0]  irq_out
);
  localparam int RW = N_CORES + N_PINS;
  localparam int LW = $clog2(N_LINES);
  localparam int NO = N_CORES * N_PINS;
  localparam logic [AW-1:0] A_PEND = AW'('h20);
  localparam logic [AW-1:0] A_EN   = AW'('h24);
  localparam logic [AW-1:0] A_SET  = AW'('h28);
  localparam logic [AW-1:0] A_CLR  = AW'('h2C);
  localparam int CORE_BASE   = 'h40;
  localparam int CORE_STRIDE = 8;

  logic [RW-1:0]      route_q [N_LINES];
  logic [RW-1:0]      route_d [N_LINES];
  logic [N_LINES-1:0] en_q, en_d, pend_q, pend_d;
  logic [N_LINES-1:0] core_q [N_CORES];
  logic [N_LINES-1:0] core_d [N_CORES];
  logic [N_LINES-1:0] pin_d  [N_PINS];
  logic [NO-1:0]      out_d;
  logic [N_LINES-1:0] rd_val;

  wire wr       = bus_valid && bus_write;
  wire rd       = bus_valid && !bus_write;
  wire byte_acc = !bus_size && (bus_addr < AW'(N_LINES));
  wire word_acc = bus_size && (bus_addr[1:0] == 2'b00);
  wire [LW-1:0] idx = bus_addr[LW-1:0];

  always_comb begin
    route_d = route_q;
    en_d    = en_q;
    if (wr && byte_acc) route_d[idx] = bus_wdata[RW-1:0];
    if (wr && word_acc && bus_addr == A_SET) en_d = en_q | bus_wdata;
    if (wr && word_acc && bus_addr == A_CLR) en_d = en_q & ~bus_wdata;
  end

  assign pend_d = irq_in & en_d;

  always_comb begin
    for (int c = 0; c < N_CORES; c++) begin
      core_d[c] = '0;
      for (int i = 0; i < N_LINES; i++) core_d[c][i] = pend_d[i] & route_d[i][c];
    end
    for (int p = 0; p < N_PINS; p++) begin
      pin_d[p] = '0;
      for (int i = 0; i < N_LINES; i++) pin_d[p][i] = pend_d[i] & route_d[i][N_CORES+p];
    end
    for (int c = 0; c < N_CORES; c++)
      for (int p = 0; p < N_PINS; p++)
        out_d[c*N_PINS+p] = (|core_d[c]) & (|pin_d[p]);
  end

  always_comb begin
    rd_val = '0;
    if (byte_acc) rd_val = N_LINES'(route_q[idx]);
    else if (word_acc) begin
      if (bus_addr == A_PEND) rd_val = pend_q;
      if (bus_addr == A_EN)   rd_val = en_q;
      for (int c = 0; c < N_CORES; c++)
        if (bus_addr == AW'(CORE_BASE + c*CORE_STRIDE)) rd_val = core_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LINES; i++) route_q[i] <= '0;
      for (int c = 0; c < N_CORES; c++) core_q[c] <= '0;
      en_q      <= '0;
      pend_q    <= '0;
      irq_out   <= '0;
      bus_rdata <= '0;
    end else begin
      route_q   <= route_d;
      core_q    <= core_d;
      en_q      <= en_d;
      pend_q    <= pend_d;
      irq_out   <= out_d;
      bus_rdata <= rd ? rd_val : '0;
    end
  end

  AST_PEND_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == '0); // R1
  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> pend_q == ($past(irq_in) & $past(en_q))); // R1
  AST_NO_EN_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |-> irq_out == '0); // R6
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> bus_rdata == '0); // R10
  AST_BAD_BYTE_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !bus_size && bus_addr >= AW'(N_LINES) |=> $stable(en_q)); // R7

  for (genvar c = 0; c < N_CORES; c++) begin : g_core_chk
    AST_CORE_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (core_q[c] & ~pend_q) == '0); // R5
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin_chk
      AST_OUT_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[c*N_PINS+p] |-> core_q[c] != '0); // R6
    end
  end
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        bus_valid = 0, bus_write = 0, bus_size = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  irq_router dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #4 clk = ~clk;

  always @(posedge clk) rd_seen <= bus_valid && !bus_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected read data %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic sz, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic sz, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_size = sz; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic set_irq(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic chk_out(input logic [15:0] e, input string t);
    n_cmp++;
    if (irq_out !== e) begin
      n_bad++;
      $display("FAIL %s irq_out %h expected %h", t, irq_out, e);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_out(16'h0, "R9 reset outputs");
    n_cmp++;
    if (bus_rdata !== 32'h0) begin n_bad++; $display("FAIL R9 rdata %h expected 0", bus_rdata); end
    rd(7'h24, 1, 32'h0, "R9 enable after reset");
    rd(7'h05, 0, 32'h0, "R9 route after reset");

    wr(7'h28, 1, 32'h0000_00FF);
    rd(7'h24, 1, 32'h0000_00FF, "R3 set");
    wr(7'h28, 1, 32'h0000_0F00);
    rd(7'h24, 1, 32'h0000_0FFF, "R3 set accumulates");
    wr(7'h2C, 1, 32'h0000_00F0);
    rd(7'h24, 1, 32'h0000_0F0F, "R3 clear");

    wr(7'h00, 0, 32'h11);
    set_irq(32'h1);
    chk_out(16'h0001, "R6 single line core0 pin0");
    rd(7'h20, 1, 32'h1, "R4 pending");
    rd(7'h40, 1, 32'h1, "R5 core0 status");
    rd(7'h00, 0, 32'h11, "R2 route readback");

    wr(7'h01, 0, 32'h02);
    wr(7'h02, 0, 32'h40);
    set_irq(32'h6);
    chk_out(16'h0040, "R6 cross-line core1 pin2");
    rd(7'h48, 1, 32'h2, "R5 core1 status");
    rd(7'h40, 1, 32'h0, "R5 core0 empty");
    rd(7'h20, 1, 32'h6, "R4 pending two lines");

    set_irq(32'h4);
    chk_out(16'h0000, "R1 no latching");
    rd(7'h20, 1, 32'h4, "R1 pending follows level");

    wr(7'h04, 0, 32'h11);
    set_irq(32'h14);
    chk_out(16'h0000, "R1 disabled line ignored");
    rd(7'h20, 1, 32'h4, "R1 disabled line not pending");

    wr(7'h2A, 1, 32'hFFFF_FFFF);
    wr(7'h28, 0, 32'hFF);
    wr(7'h30, 1, 32'hFFFF_FFFF);
    rd(7'h24, 1, 32'h0000_0F0F, "R7 bad writes ignored");
    rd(7'h44, 1, 32'h0, "R7 unmapped word read");
    rd(7'h00, 1, 32'h0, "R7 word read of route area");
    rd(7'h20, 0, 32'h0, "R7 byte read above routes");
    rd(7'h26, 1, 32'h0, "R7 misaligned read");

    wr(7'h20, 1, 32'hFFFF_FFFF);
    wr(7'h24, 1, 32'h0);
    wr(7'h40, 1, 32'hFFFF_FFFF);
    rd(7'h24, 1, 32'h0000_0F0F, "R8 enable unchanged");
    rd(7'h20, 1, 32'h4, "R8 pending unchanged");
    rd(7'h40, 1, 32'h0, "R8 core status unchanged");
    chk_out(16'h0000, "R8 outputs unchanged");

    wr(7'h00, 0, 32'hFF);
    @(negedge clk);
    irq_in = 32'h15;
    #1 chk_out(16'h0000, "R10 no change before edge");
    @(negedge clk);
    chk_out(16'hFFFF, "R10 R6 full fan-out after one edge");

    wr(7'h2C, 1, 32'h1);
    chk_out(16'h0000, "R3 R10 clear drops output at write edge");
    rd(7'h24, 1, 32'h0000_0F0E, "R3 clear single bit");

    @(negedge clk);
    @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin n_bad++; $display("FAIL R10 missing %0d read results expected 0", exp_q.size()); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule